// File: doc/BRIEF.md
# Sticky Error Status Register with System-Error Request

This block keeps a small set of hardware error flags in one 16-bit status word. Each error input latches its flag as soon as the error is seen, and the flag stays set until software clears it by writing a 1 to that bit position. The flags sit in their own reset domain: only the power-good reset returns them to zero. An ordinary warm reset leaves them unchanged, so software can still find out after a warm restart what went wrong.

Whenever a flag goes from 0 to 1, the block can raise a one-cycle system-error request. The request goes out only if two enables are on: a per-error bit in the command mask and a global signalling enable. The flags latch whatever those enables say. The block reads and writes through a simple single-address port, and all status bits above the implemented error bits read as zero.

Top module: `stickyErrStatus`

## Requirements
- R1: After power-good reset the status word reads 0000h and `sysErrReq` is low.
- R2: A write to the status address with a 1 in bit i (i below NUM_ERR) clears flag i, and a 0 in bit i leaves it unchanged. The flag value is visible on the read port the cycle after the write edge.
- R3: A high `errIn[i]` at a clock edge sets flag i, whatever the states of `errCmdMask` and `globalSerrEn`.
- R4: `sysErrReq` is high for exactly the one cycle after an edge at which some flag i was 0, `errIn[i]` was high, `errCmdMask[i]` was high and `globalSerrEn` was high.
- R5: No request is raised for a rising flag whose `errCmdMask` bit is low, or when `globalSerrEn` is low.
- R6: An error on a flag that is already set raises no request. This holds while an error input stays high over several cycles.
- R7: When an error and a software clear hit the same flag at the same edge, the error wins and the flag is 1 afterwards.
- R8: Several flags that rise at the same edge produce a single one-cycle request.
- R9: A warm reset (`warmRstN` low) leaves the flags unchanged and holds `sysErrReq` low. Errors still latch while it is applied.
- R10: Bits 15:NUM_ERR (15:2 with the defaults) always read as 0, and writing ones to them has no effect.
- R11: Reads and writes only act at address STATUS_ADDR (default 10h). A read at any other address returns 0, and a write there changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwrGoodRstN | input | 1 | Asynchronous active-low power-good reset; clears the flags |
| warmRstN | input | 1 | Asynchronous active-low warm reset; clears only the request logic |
| errIn | input | NUM_ERR | Error detect inputs, one per flag |
| errCmdMask | input | NUM_ERR | Per-error enable for request signalling |
| globalSerrEn | input | 1 | Global system-error signalling enable |
| regAddr | input | ADDR_WIDTH | Register access address |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | REG_WIDTH | Write data (1 clears a flag) |
| regRdData | output | REG_WIDTH | Read data of the addressed register, 0 if no hit |
| sysErrReq | output | 1 | One-cycle system-error message request |

## Verification
The main sweep covers every pair of starting flag state and error pattern, and pairs each one with every clear pattern, every command mask and both global enable values. It computes the expected flags as (old and not clear) or error, and the expected request as the global enable and any rising, unmasked bit. This tells apart set-versus-clear priority, masking on each of the two levels, new errors versus repeated errors, and several flags rising together. Directed sequences then hold an error high over several cycles and write to the reserved bits and to a foreign address. They also apply a warm reset with errors arriving during it, then a power-good reset, which separates the two reset domains.

// File: rtl/errStatPkg.sv
package errStatPkg;
  // Strobes decoded by the control half and consumed by the datapath half.
  typedef struct packed {
    logic wrHit;  // write strobe aimed at the status address
    logic rdHit;  // current address selects the status register
  } busStrobe_t;
endpackage

// File: rtl/errStatCtrl.sv
module errStatCtrl
  import errStatPkg::*;
#(
  parameter int unsigned ADDR_WIDTH  = 8,
  parameter int unsigned NUM_ERR     = 2,
  parameter logic [ADDR_WIDTH-1:0] STATUS_ADDR = 'h10
) (
  input  logic                  clk,
  input  logic                  pwrGoodRstN,
  input  logic                  warmRstN,
  input  logic [ADDR_WIDTH-1:0] regAddr,
  input  logic                  regWrEn,
  input  logic [NUM_ERR-1:0]    riseVec,
  input  logic [NUM_ERR-1:0]    errCmdMask,
  input  logic                  globalSerrEn,
  output busStrobe_t            strobe,
  output logic                  sysErrReq
);
  logic addrHit;
  logic reqRstN;
  logic [NUM_ERR-1:0] armedRise;
  logic fireNext;

  // Either reset silences the request path; flags are handled elsewhere.
  assign reqRstN = pwrGoodRstN & warmRstN;

  assign addrHit      = (regAddr == STATUS_ADDR);
  assign strobe.rdHit = addrHit;
  assign strobe.wrHit = addrHit & regWrEn;

  // Only flags making a fresh 0->1 step and enabled on both levels count.
  assign armedRise = riseVec & errCmdMask;
  assign fireNext  = globalSerrEn & (|armedRise);

  always_ff @(posedge clk or negedge reqRstN) begin
    if (!reqRstN) sysErrReq <= 1'b0;
    else          sysErrReq <= fireNext;
  end
endmodule

// File: rtl/errStatDatapath.sv
module errStatDatapath
  import errStatPkg::*;
#(
  parameter int unsigned REG_WIDTH = 16,
  parameter int unsigned NUM_ERR   = 2
) (
  input  logic                 clk,
  input  logic                 pwrGoodRstN,
  input  busStrobe_t           strobe,
  input  logic [REG_WIDTH-1:0] wrData,
  input  logic [NUM_ERR-1:0]   errIn,
  output logic [REG_WIDTH-1:0] flags,
  output logic [NUM_ERR-1:0]   riseVec,
  output logic [REG_WIDTH-1:0] rdData
);
  localparam logic [REG_WIDTH-1:0] IMPL_MASK = REG_WIDTH'((1 << NUM_ERR) - 1);

  logic [REG_WIDTH-1:0] flagsQ;
  logic [REG_WIDTH-1:0] clearMask;
  logic [REG_WIDTH-1:0] errWide;
  logic [REG_WIDTH-1:0] flagsNext;

  assign errWide   = REG_WIDTH'(errIn);
  assign clearMask = strobe.wrHit ? wrData : '0;
  // Set dominates clear; reserved positions are forced to zero.
  assign flagsNext = ((flagsQ & ~clearMask) | errWide) & IMPL_MASK;

  // Sticky storage: only the power-good reset reaches it.
  always_ff @(posedge clk or negedge pwrGoodRstN) begin
    if (!pwrGoodRstN) flagsQ <= '0;
    else              flagsQ <= flagsNext;
  end

  assign riseVec = errIn & ~flagsQ[NUM_ERR-1:0];
  assign flags   = flagsQ;
  assign rdData  = strobe.rdHit ? flagsQ : '0;
endmodule

// File: rtl/stickyErrStatus.sv
module stickyErrStatus
  import errStatPkg::*;
#(
  parameter int unsigned REG_WIDTH  = 16,
  parameter int unsigned NUM_ERR    = 2,
  parameter int unsigned ADDR_WIDTH = 8,
  parameter logic [ADDR_WIDTH-1:0] STATUS_ADDR = 'h10
) (
  input  logic                  clk,
  input  logic                  pwrGoodRstN,
  input  logic                  warmRstN,
  input  logic [NUM_ERR-1:0]    errIn,
  input  logic [NUM_ERR-1:0]    errCmdMask,
  input  logic                  globalSerrEn,
  input  logic [ADDR_WIDTH-1:0] regAddr,
  input  logic                  regWrEn,
  input  logic [REG_WIDTH-1:0]  regWrData,
  output logic [REG_WIDTH-1:0]  regRdData,
  output logic                  sysErrReq
);
  busStrobe_t           strobe;
  logic [NUM_ERR-1:0]   riseVec;
  logic [REG_WIDTH-1:0] statusFlags;

  errStatCtrl #(
    .ADDR_WIDTH (ADDR_WIDTH),
    .NUM_ERR    (NUM_ERR),
    .STATUS_ADDR(STATUS_ADDR)
  ) ctrl (
    .clk         (clk),
    .pwrGoodRstN (pwrGoodRstN),
    .warmRstN    (warmRstN),
    .regAddr     (regAddr),
    .regWrEn     (regWrEn),
    .riseVec     (riseVec),
    .errCmdMask  (errCmdMask),
    .globalSerrEn(globalSerrEn),
    .strobe      (strobe),
    .sysErrReq   (sysErrReq)
  );

  errStatDatapath #(
    .REG_WIDTH(REG_WIDTH),
    .NUM_ERR  (NUM_ERR)
  ) dpath (
    .clk        (clk),
    .pwrGoodRstN(pwrGoodRstN),
    .strobe     (strobe),
    .wrData     (regWrData),
    .errIn      (errIn),
    .flags      (statusFlags),
    .riseVec    (riseVec),
    .rdData     (regRdData)
  );
endmodule

// File: rtl/stickyErrStatusChecker.sv
module stickyErrStatusChecker #(
  parameter int unsigned REG_WIDTH  = 16,
  parameter int unsigned NUM_ERR    = 2,
  parameter int unsigned ADDR_WIDTH = 8,
  parameter logic [ADDR_WIDTH-1:0] STATUS_ADDR = 'h10
) (
  input logic                  clk,
  input logic                  pwrGoodRstN,
  input logic                  warmRstN,
  input logic [NUM_ERR-1:0]    errIn,
  input logic [NUM_ERR-1:0]    errCmdMask,
  input logic                  globalSerrEn,
  input logic [ADDR_WIDTH-1:0] regAddr,
  input logic                  regWrEn,
  input logic [REG_WIDTH-1:0]  regWrData,
  input logic [REG_WIDTH-1:0]  regRdData,
  input logic                  sysErrReq,
  input logic [REG_WIDTH-1:0]  statusFlags
);
  logic anyRst;
  assign anyRst = !pwrGoodRstN || !warmRstN;

  // R4 / R5: a request needs the global enable and an enabled, fresh rise.
  assert_req_enabled_R5: assert property (@(posedge clk) disable iff (anyRst)
    sysErrReq |-> ($past(globalSerrEn) &&
                   (|($past(errCmdMask) & statusFlags[NUM_ERR-1:0] &
                      ~$past(statusFlags[NUM_ERR-1:0])))));

  // R6: a request only follows a flag that was clear before.
  assert_req_fresh_R6: assert property (@(posedge clk) disable iff (anyRst)
    sysErrReq |-> (|(~$past(statusFlags[NUM_ERR-1:0]) & $past(errIn))));

  // R3: every error seen at an edge leaves its flag set.
  assert_err_latches_R3: assert property (@(posedge clk) disable iff (anyRst)
    (($past(errIn) & ~statusFlags[NUM_ERR-1:0]) == '0));

  // R2 / R11: a flag only falls when a write to the status address cleared it.
  assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (anyRst)
    (($past(statusFlags) & ~statusFlags &
      ~(($past(regWrEn) && ($past(regAddr) == STATUS_ADDR)) ? $past(regWrData) : '0)) == '0));

  // R10: reserved positions never read as one.
  assert_rsvd_zero_R10: assert property (@(posedge clk) disable iff (!pwrGoodRstN)
    (regRdData >> NUM_ERR) == '0);
endmodule

bind stickyErrStatus stickyErrStatusChecker #(
  .REG_WIDTH  (REG_WIDTH),
  .NUM_ERR    (NUM_ERR),
  .ADDR_WIDTH (ADDR_WIDTH),
  .STATUS_ADDR(STATUS_ADDR)
) chk (
  .clk         (clk),
  .pwrGoodRstN (pwrGoodRstN),
  .warmRstN    (warmRstN),
  .errIn       (errIn),
  .errCmdMask  (errCmdMask),
  .globalSerrEn(globalSerrEn),
  .regAddr     (regAddr),
  .regWrEn     (regWrEn),
  .regWrData   (regWrData),
  .regRdData   (regRdData),
  .sysErrReq   (sysErrReq),
  .statusFlags (statusFlags)
);

// File: tb/stickyErrStatus_test.sv
`timescale 1ns/1ps
module stickyErrStatus_test;
  localparam int REG_WIDTH = 16;
  localparam int NUM_ERR   = 2;
  localparam int ADDR_WIDTH = 8;
  localparam logic [7:0] STATUS_ADDR = 8'h10;
  localparam logic [7:0] OTHER_ADDR  = 8'h24;

  logic clk = 1'b0;
  logic pwrGoodRstN = 1'b0;
  logic warmRstN = 1'b0;
  logic [NUM_ERR-1:0] errIn = '0;
  logic [NUM_ERR-1:0] errCmdMask = '0;
  logic globalSerrEn = 1'b0;
  logic [ADDR_WIDTH-1:0] regAddr = STATUS_ADDR;
  logic regWrEn = 1'b0;
  logic [REG_WIDTH-1:0] regWrData = '0;
  logic [REG_WIDTH-1:0] regRdData;
  logic sysErrReq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  stickyErrStatus uut (
    .clk(clk), .pwrGoodRstN(pwrGoodRstN), .warmRstN(warmRstN),
    .errIn(errIn), .errCmdMask(errCmdMask), .globalSerrEn(globalSerrEn),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .sysErrReq(sysErrReq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Bring the flags to a known pattern with signalling off.
  task automatic setFlags(input logic [NUM_ERR-1:0] pat);
    errCmdMask = '0; globalSerrEn = 1'b0; regAddr = STATUS_ADDR;
    regWrEn = 1'b1; regWrData = '1; errIn = '0;
    tick();
    regWrEn = 1'b0; regWrData = '0; errIn = pat;
    tick();
    errIn = '0;
    tick();
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [NUM_ERR-1:0] expFlags;
    logic expReq;
    tick();
    pwrGoodRstN = 1'b1; warmRstN = 1'b1;
    tick();
    check("R1 reset flags", regRdData, 0);
    check("R1 reset request", sysErrReq, 0);

    // Exhaustive sweep: start state x error x clear x mask x global (R2..R8).
    for (int init = 0; init < 4; init++)
      for (int err = 0; err < 4; err++)
        for (int clr = 0; clr < 4; clr++)
          for (int msk = 0; msk < 4; msk++)
            for (int g = 0; g < 2; g++) begin
              setFlags(NUM_ERR'(init));
              errIn = NUM_ERR'(err); errCmdMask = NUM_ERR'(msk); globalSerrEn = g[0];
              regWrEn = (clr != 0); regWrData = REG_WIDTH'(clr);
              expFlags = (NUM_ERR'(init) & ~NUM_ERR'(clr)) | NUM_ERR'(err);
              expReq = g[0] && ((NUM_ERR'(err) & ~NUM_ERR'(init) & NUM_ERR'(msk)) != 0);
              tick();
              // R2 R3 R7: clear/set priority on the flags
              check("R2 R3 R7 flags", regRdData, 32'(expFlags));
              // R4 R5 R6 R8: request on fresh enabled rise only
              check("R4 R5 R6 R8 request", sysErrReq, 32'(expReq));
              errIn = '0; regWrEn = 1'b0;
              tick();
              check("R4 single-cycle request", sysErrReq, 0);
            end

    // R6: an error held high fires once.
    setFlags('0);
    errCmdMask = '1; globalSerrEn = 1'b1; errIn = 2'b01;
    tick();
    check("R6 first cycle", sysErrReq, 1);
    tick();
    check("R6 held error cycle 2", sysErrReq, 0);
    tick();
    check("R6 held error cycle 3", sysErrReq, 0);
    errIn = '0; tick();

    // R10: reserved writes ignored, reserved bits read zero.
    setFlags(2'b11);
    regWrEn = 1'b1; regWrData = 16'hFFFC;
    tick();
    regWrEn = 1'b0;
    check("R10 reserved write", regRdData, 32'h3);

    // R11: foreign address write and read.
    regAddr = OTHER_ADDR; regWrEn = 1'b1; regWrData = 16'hFFFF;
    tick();
    regWrEn = 1'b0;
    check("R11 foreign read", regRdData, 0);
    regAddr = STATUS_ADDR; #1;
    check("R11 foreign write", regRdData, 32'h3);

    // R9: warm reset keeps flags, blocks request, errors still latch.
    setFlags(2'b10);
    errCmdMask = '1; globalSerrEn = 1'b1;
    warmRstN = 1'b0;
    tick();
    check("R9 flags kept", regRdData, 32'h2);
    errIn = 2'b01;
    tick();
    errIn = '0;
    check("R9 request held low", sysErrReq, 0);
    check("R9 R3 latch in warm reset", regRdData, 32'h3);
    warmRstN = 1'b1;
    tick();
    check("R9 after release", regRdData, 32'h3);

    // R1: power-good reset clears sticky flags.
    pwrGoodRstN = 1'b0;
    tick();
    pwrGoodRstN = 1'b1;
    tick();
    check("R1 power-good clears", regRdData, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule